// File: doc/BRIEF.md
# Packet FIFO and Interrupt Steering Controller

This block holds packet payload bytes in a byte FIFO between a host and an abstract radio bit engine. The host reaches the FIFO only in standby mode, and a single control bit chooses whether the host writes the FIFO or reads it. In transmit mode the block starts a packet without help from the host. It passes a fixed number of bytes to the bit engine when the engine asks for them. It signals completion one bit period after the engine reports that the last bit has gone out. Any bytes left in the FIFO beyond the packet length are discarded at that point.

In receive mode the block stores bytes from the bit engine. In fixed-length format it keeps up to the programmed length. In variable-length format it keeps a leading length byte and then that many bytes, and the programmed length is the largest it accepts. The CRC verdict arrives as a strobe. A good verdict raises a packet-good flag. A bad verdict empties the FIFO when autoclear is enabled. Two interrupt lines are each driven by a multiplexer. Its source-select fields change meaning with the mode, and both lines are held low in sleep.

Top module: `pktFifoCtl`

## Requirements
- R1: In standby with `stbyRead`=0 each `hostWr` stores `hostWrData`. With `stbyRead`=1, `hostRdData` shows the oldest byte and each `hostRd` removes it, so bytes leave in the order they were written.
- R2: A write to a full FIFO and a read from an empty FIFO leave the contents unchanged and set the sticky `fifoErr`. `fifoErr` clears in sleep (`mode`=0). Host strobes in sleep do not change the fill level.
- R3: `fifoLevel` never exceeds DEPTH. The threshold flag is true when `fifoLevel` > `thresh`. In standby or receive it appears on `irq0` when `rxIrq0Sel`=2'b00.
- R4: Mode encoding: 0 sleep, 1 standby, 2 transmit, 3 receive. With `txStartSel`=1 the block starts a packet when it is in transmit mode, `txReady` is high and the FIFO is not empty. `txBusy` rises one cycle later. With an empty FIFO or with `txReady` low, `txBusy` stays low.
- R5: While busy the block removes one byte per `txByteReq`, presenting it on `txByte` in FIFO order, for exactly `pktLen` bytes (`pktLen` ≥ 1). Further requests leave the FIFO unchanged.
- R6: With `txIrq1Sel`=1 in transmit mode, `irq1` is a one-cycle done pulse. It rises exactly BIT_CYCLES clock edges after the edge that samples `txLastBit`.
- R7: With `txStartSel`=1, bytes left in the FIFO when the done pulse rises are discarded, so `fifoLevel` is 0 while `irq1` is high.
- R8: In receive with `varLen`=0 the first `pktLen` bytes of a packet are stored and any later bytes are ignored until the CRC strobe.
- R9: In receive with `varLen`=1 the first byte L is stored and L more bytes are accepted. If L > `pktLen`, the FIFO is emptied and the rest of the packet is ignored until the CRC strobe.
- R10: A `crcPulse` with `crcOk`=1 in receive sets a packet-good flag. With `rxIrq1Sel`=2'b00 this flag drives `irq1` in standby and receive until the next stored byte. A `crcPulse` with `crcOk`=0 and `autoClr`=1 empties the FIFO. With `autoClr`=0 the FIFO keeps its bytes.
- R11: With `rxIrq0Sel`=2'b10 in standby or receive, `irq0` is high exactly when the FIFO is not empty. In sleep both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| mode | input | 2 | 0 sleep, 1 standby, 2 transmit, 3 receive |
| txStartSel | input | 1 | 1: start on non-empty FIFO, 0: start on threshold |
| txIrq1Sel | input | 1 | Transmit irq1 source: 1 done pulse, 0 threshold |
| rxIrq0Sel | input | 2 | Standby/receive irq0 source: 00 threshold, 01 full, 10 not empty, 11 error |
| rxIrq1Sel | input | 2 | Standby/receive irq1 source: 00 packet good, 01 full, 10 threshold, 11 error |
| stbyRead | input | 1 | Standby host access: 0 write, 1 read |
| autoClr | input | 1 | Empty FIFO on CRC failure |
| varLen | input | 1 | Receive format: 1 variable length, 0 fixed |
| pktLen | input | 8 | Packet length or maximum receive length |
| thresh | input | LW | Fill threshold |
| hostWr | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRd | input | 1 | Host read strobe |
| hostRdData | output | 8 | Oldest FIFO byte |
| txReady | input | 1 | Transmitter ready |
| txByteReq | input | 1 | Bit engine byte request |
| txLastBit | input | 1 | Last payload bit left the serializer |
| txByte | output | 8 | Byte handed to bit engine |
| txBusy | output | 1 | Packet transmission in progress |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| crcPulse | input | 1 | CRC verdict strobe |
| crcOk | input | 1 | CRC verdict, valid with crcPulse |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| fifoLevel | output | LW | Bytes held |
| fifoErr | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions assume that the mode and the select fields stay put while a packet is in flight. They also assume that `crcPulse` never coincides with `rxValid` and that `txLastBit` comes only after the last byte has been requested. The bench changes configuration only while the block is in standby or sleep. It issues every engine strobe as an isolated one-cycle pulse separated by idle cycles, and it raises the last-bit strobe only after the final byte request.

// File: rtl/pktfifo_pkg.sv
package pktfifo_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_TX    = 2'd2,
    MODE_RX    = 2'd3
  } modeE;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic       clear;
    logic       errClr;
    logic [7:0] pushData;
  } fifoCmdT;
endpackage

// File: rtl/pktFifoData.sv
module pktFifoData
  import pktfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCmdT       cmd,
  output logic [LW-1:0] level,
  output logic [7:0]    headData,
  output logic          full,
  output logic          empty,
  output logic          errFlag
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign headData = mem[rdPtr];
  assign doPush   = cmd.push && !full && !cmd.clear;
  assign doPop    = cmd.pop && !empty && !cmd.clear;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= cmd.pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + LW'(1);
      else if (doPop && !doPush) level <= level - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      errFlag <= 1'b0;
    else if (cmd.errClr)                            errFlag <= 1'b0;
    else if ((cmd.push && full) || (cmd.pop && empty)) errFlag <= 1'b1;
  end
endmodule

// File: rtl/pktFifoCtrl.sv
module pktFifoCtrl
  import pktfifo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int BIT_CYCLES = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int TW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    mode,
  input  logic          txStartSel,
  input  logic          txIrq1Sel,
  input  logic [1:0]    rxIrq0Sel,
  input  logic [1:0]    rxIrq1Sel,
  input  logic          stbyRead,
  input  logic          autoClr,
  input  logic          varLen,
  input  logic [7:0]    pktLen,
  input  logic [LW-1:0] thresh,
  input  logic          hostWr,
  input  logic [7:0]    hostWrData,
  input  logic          hostRd,
  input  logic          txReady,
  input  logic          txByteReq,
  input  logic          txLastBit,
  input  logic          rxValid,
  input  logic [7:0]    rxByte,
  input  logic          crcPulse,
  input  logic          crcOk,
  input  logic [LW-1:0] level,
  input  logic          full,
  input  logic          empty,
  input  logic          errFlag,
  output fifoCmdT       cmd,
  output logic          irq0,
  output logic          irq1,
  output logic          txBusy
);
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_TAIL, TX_HOLD} txStE;

  modeE          curMode;
  logic          threshOver;
  txStE          txSt;
  logic [7:0]    sentQ;
  logic [TW-1:0] tmrQ;
  logic          txDoneQ, txStartOk, txPop, txClr;
  logic [8:0]    rxCntQ, rxTgtQ, rxLimit;
  logic          rxDropQ, pktOkQ;
  logic          rxIn, rxFirstVar, lenBad, rxPush, crcEv, crcClr;
  logic          hostPush, hostPop;

  assign curMode    = modeE'(mode);
  assign threshOver = (level > thresh);

  // transmit sequencing
  assign txStartOk = (curMode == MODE_TX) && txReady && (txStartSel ? !empty : threshOver);
  assign txPop     = (txSt == TX_SEND) && txByteReq;
  assign txClr     = (txSt == TX_HOLD) && (tmrQ == '0) && txStartSel && !empty;
  assign txBusy    = (txSt != TX_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSt    <= TX_IDLE;
      sentQ   <= '0;
      tmrQ    <= '0;
      txDoneQ <= 1'b0;
    end else begin
      txDoneQ <= 1'b0;
      if (curMode != MODE_TX) txSt <= TX_IDLE;
      else begin
        unique case (txSt)
          TX_IDLE: if (txStartOk) begin
            txSt  <= TX_SEND;
            sentQ <= '0;
          end
          TX_SEND: if (txPop) begin
            sentQ <= sentQ + 8'd1;
            if ({1'b0, sentQ} + 9'd1 >= {1'b0, pktLen}) txSt <= TX_TAIL;
          end
          TX_TAIL: if (txLastBit) begin
            txSt <= TX_HOLD;
            tmrQ <= TW'(BIT_CYCLES - 1);
          end
          TX_HOLD: if (tmrQ == '0) begin
            txSt    <= TX_IDLE;
            txDoneQ <= 1'b1;
          end else tmrQ <= tmrQ - TW'(1);
          default: txSt <= TX_IDLE;
        endcase
      end
    end
  end

  // receive acceptance
  assign rxIn       = (curMode == MODE_RX) && rxValid && !rxDropQ;
  assign rxFirstVar = varLen && (rxCntQ == '0);
  assign lenBad     = rxIn && rxFirstVar && (rxByte > pktLen);
  assign rxLimit    = varLen ? rxTgtQ : {1'b0, pktLen};
  assign rxPush     = rxIn && !lenBad && (rxFirstVar || (rxCntQ < rxLimit));
  assign crcEv      = (curMode == MODE_RX) && crcPulse;
  assign crcClr     = crcEv && !crcOk && autoClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCntQ  <= '0;
      rxTgtQ  <= '0;
      rxDropQ <= 1'b0;
    end else if ((curMode != MODE_RX) || crcEv) begin
      rxCntQ  <= '0;
      rxDropQ <= 1'b0;
    end else begin
      if (lenBad) rxDropQ <= 1'b1;
      if (rxPush) rxCntQ <= rxCntQ + 9'd1;
      if (rxPush && rxFirstVar) rxTgtQ <= {1'b0, rxByte} + 9'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pktOkQ <= 1'b0;
    else if ((curMode == MODE_SLEEP) || (curMode == MODE_TX) || rxPush) pktOkQ <= 1'b0;
    else if (crcEv && crcOk) pktOkQ <= 1'b1;
  end

  // strobes to the datapath
  assign hostPush = (curMode == MODE_STBY) && !stbyRead && hostWr;
  assign hostPop  = (curMode == MODE_STBY) && stbyRead && hostRd;

  always_comb begin
    cmd          = '0;
    cmd.push     = hostPush || rxPush;
    cmd.pop      = hostPop || txPop;
    cmd.clear    = lenBad || crcClr || txClr;
    cmd.errClr   = (curMode == MODE_SLEEP);
    cmd.pushData = (curMode == MODE_RX) ? rxByte : hostWrData;
  end

  // interrupt steering
  always_comb begin
    irq0 = 1'b0;
    irq1 = 1'b0;
    unique case (curMode)
      MODE_SLEEP: begin
        irq0 = 1'b0;
        irq1 = 1'b0;
      end
      MODE_TX: begin
        irq0 = txStartSel ? !empty : threshOver;
        irq1 = txIrq1Sel ? txDoneQ : threshOver;
      end
      default: begin
        unique case (rxIrq0Sel)
          2'b00:   irq0 = threshOver;
          2'b01:   irq0 = full;
          2'b10:   irq0 = !empty;
          default: irq0 = errFlag;
        endcase
        unique case (rxIrq1Sel)
          2'b00:   irq1 = pktOkQ;
          2'b01:   irq1 = full;
          2'b10:   irq1 = threshOver;
          default: irq1 = errFlag;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/pktFifoCtl.sv
module pktFifoCtl
  import pktfifo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int BIT_CYCLES = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    mode,
  input  logic          txStartSel,
  input  logic          txIrq1Sel,
  input  logic [1:0]    rxIrq0Sel,
  input  logic [1:0]    rxIrq1Sel,
  input  logic          stbyRead,
  input  logic          autoClr,
  input  logic          varLen,
  input  logic [7:0]    pktLen,
  input  logic [LW-1:0] thresh,
  input  logic          hostWr,
  input  logic [7:0]    hostWrData,
  input  logic          hostRd,
  output logic [7:0]    hostRdData,
  input  logic          txReady,
  input  logic          txByteReq,
  input  logic          txLastBit,
  output logic [7:0]    txByte,
  output logic          txBusy,
  input  logic          rxValid,
  input  logic [7:0]    rxByte,
  input  logic          crcPulse,
  input  logic          crcOk,
  output logic          irq0,
  output logic          irq1,
  output logic [LW-1:0] fifoLevel,
  output logic          fifoErr
);
  fifoCmdT    cmd;
  logic [7:0] headData;
  logic       full, empty;

  pktFifoData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .level(fifoLevel), .headData(headData),
    .full(full), .empty(empty), .errFlag(fifoErr)
  );

  pktFifoCtrl #(.DEPTH(DEPTH), .BIT_CYCLES(BIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .txStartSel(txStartSel), .txIrq1Sel(txIrq1Sel),
    .rxIrq0Sel(rxIrq0Sel), .rxIrq1Sel(rxIrq1Sel), .stbyRead(stbyRead), .autoClr(autoClr),
    .varLen(varLen), .pktLen(pktLen), .thresh(thresh), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRd(hostRd), .txReady(txReady), .txByteReq(txByteReq),
    .txLastBit(txLastBit), .rxValid(rxValid), .rxByte(rxByte), .crcPulse(crcPulse),
    .crcOk(crcOk), .level(fifoLevel), .full(full), .empty(empty), .errFlag(fifoErr),
    .cmd(cmd), .irq0(irq0), .irq1(irq1), .txBusy(txBusy)
  );

  assign hostRdData = headData;
  assign txByte     = headData;
endmodule

// File: rtl/pktFifoCtl_chk.sv
module pktFifoCtl_chk
  import pktfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    mode,
  input logic          txStartSel,
  input logic          txIrq1Sel,
  input logic [1:0]    rxIrq0Sel,
  input logic          autoClr,
  input logic          crcPulse,
  input logic          crcOk,
  input logic          irq0,
  input logic          irq1,
  input logic [LW-1:0] fifoLevel
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LW'(DEPTH)); // R3

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP) |-> (!irq0 && !irq1)); // R11

  AST_NOT_EMPTY_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_RX || mode == MODE_STBY) && rxIrq0Sel == 2'b10) |-> (irq0 == (fifoLevel != '0))); // R11

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP) |=> $stable(fifoLevel)); // R2

  AST_CRC_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RX && crcPulse && !crcOk && autoClr) |=> (fifoLevel == '0)); // R10

  AST_SURPLUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TX && txStartSel && txIrq1Sel && irq1) |-> (fifoLevel == '0)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TX && txIrq1Sel && irq1) |=> !(mode == MODE_TX && txIrq1Sel && irq1)); // R6
endmodule

bind pktFifoCtl pktFifoCtl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .txStartSel(txStartSel), .txIrq1Sel(txIrq1Sel),
  .rxIrq0Sel(rxIrq0Sel), .autoClr(autoClr), .crcPulse(crcPulse), .crcOk(crcOk),
  .irq0(irq0), .irq1(irq1), .fifoLevel(fifoLevel)
);

// File: tb/pktFifoCtl_tb.sv
module pktFifoCtl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int BITC       = 3;
  localparam int LW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    mode = 2'd1;
  logic          txStartSel = 1'b1, txIrq1Sel = 1'b1;
  logic [1:0]    rxIrq0Sel = 2'b10, rxIrq1Sel = 2'b00;
  logic          stbyRead = 1'b0, autoClr = 1'b1, varLen = 1'b0;
  logic [7:0]    pktLen = 8'd4;
  logic [LW-1:0] thresh = '0;
  logic          hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]    hostWrData = '0;
  logic [7:0]    hostRdData, txByte, rxByte = '0;
  logic          txReady = 1'b0, txByteReq = 1'b0, txLastBit = 1'b0, txBusy;
  logic          rxValid = 1'b0, crcPulse = 1'b0, crcOk = 1'b0;
  logic          irq0, irq1, fifoErr;
  logic [LW-1:0] fifoLevel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pktFifoCtl #(.DEPTH(DEPTH), .BIT_CYCLES(BITC)) u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .txStartSel(txStartSel), .txIrq1Sel(txIrq1Sel),
    .rxIrq0Sel(rxIrq0Sel), .rxIrq1Sel(rxIrq1Sel), .stbyRead(stbyRead), .autoClr(autoClr),
    .varLen(varLen), .pktLen(pktLen), .thresh(thresh), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRd(hostRd), .hostRdData(hostRdData), .txReady(txReady),
    .txByteReq(txByteReq), .txLastBit(txLastBit), .txByte(txByte), .txBusy(txBusy),
    .rxValid(rxValid), .rxByte(rxByte), .crcPulse(crcPulse), .crcOk(crcOk),
    .irq0(irq0), .irq1(irq1), .fifoLevel(fifoLevel), .fifoErr(fifoErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] d);
    hostWrData = d; hostWr = 1'b1; tick(); hostWr = 1'b0;
  endtask

  task automatic hostRead();
    hostRd = 1'b1; tick(); hostRd = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] d);
    rxByte = d; rxValid = 1'b1; tick(); rxValid = 1'b0; tick();
  endtask

  task automatic crcStrobe(input bit ok);
    crcOk = ok; crcPulse = 1'b1; tick(); crcPulse = 1'b0; tick();
  endtask

  task automatic drainSleep();
    mode = 2'd1; stbyRead = 1'b1;
    for (int k = 0; k < DEPTH + 1; k++) hostRead();
    mode = 2'd0; tick(); mode = 2'd1; stbyRead = 1'b0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lvl, fill, expLvl, first;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // reset state
    check(fifoLevel == 0, "R3 reset level", int'(fifoLevel), 0);
    check(!fifoErr, "R2 reset err", int'(fifoErr), 0);
    check(!irq0 && !irq1, "R11 reset irqs", int'({irq0, irq1}), 0);

    // host write/read sweep with threshold sweep
    for (int n = 0; n <= DEPTH + 2; n++) begin
      mode = 2'd1; stbyRead = 1'b0;
      for (int i = 0; i < n; i++) hostWrite(8'((n * 16 + i * 5) & 255));
      lvl = (n > DEPTH) ? DEPTH : n;
      check(int'(fifoLevel) == lvl, "R1 level after writes", int'(fifoLevel), lvl);
      check(fifoErr == (n > DEPTH), "R2 overflow flag", int'(fifoErr), int'(n > DEPTH));
      rxIrq0Sel = 2'b10; tick();
      check(irq0 == (lvl != 0), "R11 irq0 not empty", int'(irq0), int'(lvl != 0));
      rxIrq0Sel = 2'b00;
      for (int t = 0; t <= DEPTH; t++) begin
        thresh = LW'(t); tick();
        check(irq0 == (lvl > t), "R3 threshold flag", int'(irq0), int'(lvl > t));
      end
      rxIrq0Sel = 2'b10; thresh = '0;
      stbyRead = 1'b1;
      for (int i = 0; i < lvl; i++) begin
        check(hostRdData == 8'((n * 16 + i * 5) & 255), "R1 read order", int'(hostRdData),
              (n * 16 + i * 5) & 255);
        hostRead();
      end
      mode = 2'd0; tick();
      check(!fifoErr, "R2 err cleared in sleep", int'(fifoErr), 0);
      mode = 2'd1; hostRead();
      check(fifoErr && fifoLevel == 0, "R2 empty read ignored", int'(fifoLevel), 0);
      mode = 2'd0; hostWr = 1'b1; hostRd = 1'b1; tick(); tick();
      hostWr = 1'b0; hostRd = 1'b0;
      check(fifoLevel == 0 && !irq0 && !irq1, "R2 sleep ignores host", int'(fifoLevel), 0);
    end

    // transmit: empty FIFO and not-ready do not start
    mode = 2'd2; txReady = 1'b1; txStartSel = 1'b1; txIrq1Sel = 1'b1;
    repeat (3) tick();
    check(!txBusy, "R4 no start when empty", int'(txBusy), 0);
    mode = 2'd1; stbyRead = 1'b0; hostWrite(8'h11); txReady = 1'b0; mode = 2'd2;
    repeat (3) tick();
    check(!txBusy, "R4 no start when not ready", int'(txBusy), 0);
    mode = 2'd1; drainSleep();

    // transmit sweep over length and surplus
    for (int len = 1; len <= 3; len++) begin
      for (int extra = 0; extra <= 2; extra++) begin
        fill = len + extra;
        mode = 2'd1; stbyRead = 1'b0; pktLen = 8'(len); txReady = 1'b1;
        for (int i = 0; i < fill; i++) hostWrite(8'(8'hA0 + len * 8 + i));
        mode = 2'd2; tick();
        check(txBusy, "R4 start one cycle after tx entry", int'(txBusy), 1);
        for (int i = 0; i < len; i++) begin
          check(txByte == 8'(8'hA0 + len * 8 + i), "R5 tx byte order", int'(txByte),
                (8'hA0 + len * 8 + i) & 255);
          txByteReq = 1'b1; tick(); txByteReq = 1'b0; tick();
        end
        check(int'(fifoLevel) == extra, "R5 popped exactly pktLen", int'(fifoLevel), extra);
        txByteReq = 1'b1; tick(); txByteReq = 1'b0; tick();
        check(int'(fifoLevel) == extra, "R5 extra request ignored", int'(fifoLevel), extra);
        txLastBit = 1'b1; tick(); txLastBit = 1'b0;
        first = -1;
        for (int k = 0; k <= BITC + 2; k++) begin
          if (irq1 && first < 0) begin
            first = k;
            check(fifoLevel == 0, "R7 surplus cleared at done", int'(fifoLevel), 0);
          end
          tick();
        end
        check(first == BITC, "R6 done delay", first, BITC);
        check(!irq1, "R6 done is a pulse", int'(irq1), 0);
        mode = 2'd1; tick();
      end
    end
    txReady = 1'b0; drainSleep();

    // receive fixed length
    varLen = 1'b0; rxIrq0Sel = 2'b10; rxIrq1Sel = 2'b00;
    for (int len = 2; len <= 4; len++) begin
      for (int v = 0; v < 3; v++) begin
        pktLen = 8'(len); mode = 2'd3; autoClr = (v != 2); tick();
        for (int i = 0; i < len + 2; i++) rxSend(8'(8'h30 + len * 4 + i));
        check(int'(fifoLevel) == len, "R8 fixed length stored", int'(fifoLevel), len);
        check(irq0, "R11 irq0 in rx", int'(irq0), 1);
        crcStrobe(v == 0);
        if (v == 0) begin
          check(irq1, "R10 crc ok flag", int'(irq1), 1);
          mode = 2'd1; stbyRead = 1'b1; tick();
          check(irq1, "R10 flag kept in standby", int'(irq1), 1);
          for (int i = 0; i < len; i++) begin
            check(hostRdData == 8'(8'h30 + len * 4 + i), "R8 rx byte order",
                  int'(hostRdData), (8'h30 + len * 4 + i) & 255);
            hostRead();
          end
        end else begin
          expLvl = (v == 1) ? 0 : len;
          check(int'(fifoLevel) == expLvl, "R10 crc fail autoclear", int'(fifoLevel), expLvl);
          check(!irq1, "R10 no good flag on fail", int'(irq1), 0);
        end
        drainSleep();
      end
    end

    // receive variable length sweep
    varLen = 1'b1; pktLen = 8'd4; autoClr = 1'b1;
    for (int lb = 0; lb <= 6; lb++) begin
      mode = 2'd3; tick();
      rxSend(8'(lb));
      for (int i = 0; i < lb + 2; i++) rxSend(8'(8'h50 + i));
      expLvl = (lb <= 4) ? lb + 1 : 0;
      check(int'(fifoLevel) == expLvl, "R9 variable length stored", int'(fifoLevel), expLvl);
      if (lb <= 4) begin
        mode = 2'd1; stbyRead = 1'b1; tick();
        check(hostRdData == 8'(lb), "R9 length byte first", int'(hostRdData), lb);
        mode = 2'd3; tick();
      end
      crcStrobe(1'b0);
      check(fifoLevel == 0, "R10 variable crc fail clear", int'(fifoLevel), 0);
      drainSleep();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule